// File: doc/BRIEF.md
# Flash Program/Erase Sequencing Controller

This controller sits between a command decoder and a multi-bank flash array. It decides whether each decoded request may proceed. The requests are program, erase, suspend, resume, lock, unlock and clear-status. It turns a word address into a block index, keeps one lock bit for every block, and tracks a single program or erase operation, including suspend and resume. It drives a status vector and a combinational read-permission signal, so a read path can tell whether a read to a given address may run while the array is busy.

The array is 16 Mwords of 16 bits, split into 16 banks of 1 Mword. The lowest 64 Kwords are divided into four 16-Kword parameter blocks. Every other 64-Kword region is one main block, which gives 259 blocks in total. The array signals the end of a program or erase on a done input. The cell timing itself is not modelled.

Top module: `fpe_seq_ctrl`

## Requirements
- R1: The block index is `addr[15:14]` when `addr[23:16]` is zero. Otherwise it is `addr[23:16] + 3`. The bank index is `addr[23:20]`. Lock, unlock, program and erase all act on the block that this rule selects.
- R2: After reset, every lock bit is set. The status reads ready, with no suspend flag and no error flag, and every read is permitted.
- R3: Lock (cmd 5) and unlock (cmd 6) change the lock bit of the addressed block, and the change applies to the next request. A program (cmd 1) or erase (cmd 2) to a locked block is refused and sets the lock-error flag.
- R4: While `vpp_lockout_i` is high, every program and erase is refused. If the request could otherwise have started, the lockout-error flag is set instead of the lock-error flag, whatever the lock bits hold.
- R5: Only one program or erase may be active at a time. A program or erase request that arrives while an operation is running is refused and sets no flag.
- R6: When `done_i` is high, a running operation ends on that cycle and any request on the same cycle is refused. `done_i` has no effect when no operation is running.
- R7: While an erase or program is running, a read is permitted only if its bank differs from the bank of the active operation.
- R8: A running erase may be suspended (cmd 3) and resumed (cmd 4). While it is suspended, a program to a different block is accepted, and a program to the erased block is refused. A read is permitted anywhere outside the erased block.
- R9: A running program may be suspended and resumed. While it is suspended, a read is permitted at every word except the programmed word, and program and erase requests are refused.
- R10: A program started during an erase suspend cannot be suspended. While it runs, a read must fall both outside its bank and outside the erased block. When it completes, the controller returns to the erase-suspended state.
- R11: A suspend outside a running erase or program is ignored and leaves the state unchanged. A resume outside a suspended state is also ignored.
- R12: The lock-error and lockout-error flags stay set until a clear-status request (cmd 7). Clear-status resets both flags.
- R13: `status_o` is {lockout error, lock error, program suspended, erase suspended, ready}, with bit 0 being ready. Ready is low only while an operation runs. `accept_o` is high in the same cycle as any request that takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | A request is present this cycle |
| req_cmd_i | input | 3 | 0 none, 1 program, 2 erase, 3 suspend, 4 resume, 5 lock, 6 unlock, 7 clear status |
| req_addr_i | input | 24 | Word address of the request |
| done_i | input | 1 | The array has finished the running operation |
| vpp_lockout_i | input | 1 | Supply below the lockout level |
| rd_addr_i | input | 24 | Word address of a prospective read |
| rd_ok_o | output | 1 | The read at `rd_addr_i` is permitted |
| accept_o | output | 1 | The current request takes effect |
| status_o | output | 5 | Status and error flags (see R13) |

## Verification
The stimulus sweeps addresses across the edges between parameter blocks, main blocks and banks. Lock and unlock go through one address, and the program that follows uses another address. This shows whether the address map groups words into the correct block. Reads are probed in the operation's own bank, in a different bank, in the suspended erase block, and at the suspended program word and the word next to it. This separates the bank-level rule, the block-level rule and the word-level rule. Requests are also placed on the same cycle as done, under supply lockout, and inside a program that runs during an erase suspend. These cases separate the priority between refusal reasons and the nested suspend states.

// File: rtl/fpe_pkg.sv
package fpe_pkg;
  typedef enum logic [2:0] {
    CMD_NOP    = 3'd0,
    CMD_PROG   = 3'd1,
    CMD_ERASE  = 3'd2,
    CMD_SUSP   = 3'd3,
    CMD_RESUME = 3'd4,
    CMD_LOCK   = 3'd5,
    CMD_UNLOCK = 3'd6,
    CMD_CLRST  = 3'd7
  } fpe_cmd_e;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_ERS,
    OP_PRG,
    OP_ERS_SUS,
    OP_PRG_SUS,
    OP_PIES      // program running inside an erase suspend
  } fpe_op_e;

  localparam int ST_READY = 0;
  localparam int ST_ESUS  = 1;
  localparam int ST_PSUS  = 2;
  localparam int ST_LKERR = 3;
  localparam int ST_VPERR = 4;
  localparam int ST_W     = 5;
endpackage

// File: rtl/fpe_addr_map.sv
module fpe_addr_map #(
  parameter int ADDR_W      = 24,
  parameter int MAIN_OFS_W  = 16,
  parameter int PARAM_OFS_W = 14,
  parameter int BLK_W       = 9
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [BLK_W-1:0]  blk_o
);
  localparam int NUM_PARAM = 1 << (MAIN_OFS_W - PARAM_OFS_W);
  localparam logic [ADDR_W-1:0] MAIN_BASE = ADDR_W'(1) << MAIN_OFS_W;

  always_comb begin
    if (addr_i < MAIN_BASE) blk_o = BLK_W'(addr_i >> PARAM_OFS_W);
    else                    blk_o = BLK_W'(addr_i >> MAIN_OFS_W) + BLK_W'(NUM_PARAM - 1);
  end
endmodule

// File: rtl/fpe_lock_bank.sv
module fpe_lock_bank #(
  parameter int NBLK  = 259,
  parameter int BLK_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             set_i,
  input  logic [BLK_W-1:0] blk_i,
  output logic             locked_o
);
  logic [NBLK-1:0] lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   lock_q <= {NBLK{1'b1}};
    else if (we_i) lock_q[blk_i] <= set_i;
  end

  assign locked_o = lock_q[blk_i];
endmodule

// File: rtl/fpe_op_fsm.sv
module fpe_op_fsm
  import fpe_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int BLK_W  = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  fpe_cmd_e          cmd_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [BLK_W-1:0]  req_blk_i,
  input  logic              req_locked_i,
  input  logic [BLK_W-1:0]  ers_blk_i,
  input  logic              vpp_lockout_i,
  input  logic              done_i,
  output logic              accept_o,
  output logic              lock_we_o,
  output logic              lock_set_o,
  output fpe_op_e           op_o,
  output logic [ADDR_W-1:0] ers_addr_o,
  output logic [ADDR_W-1:0] prg_addr_o,
  output logic              lock_err_o,
  output logic              vpp_err_o
);
  fpe_op_e op_q, op_d;
  logic [ADDR_W-1:0] ers_q, prg_q;
  logic lkerr_q, vperr_q;
  logic running, hold, live, slot_ok, pe_try, pe_vpp, pe_lock, pe_go;
  logic susp_go, res_go, clr;

  always_comb begin
    running = (op_q == OP_ERS) || (op_q == OP_PRG) || (op_q == OP_PIES);
    hold    = running && done_i;
    live    = req_valid_i && !hold;
    unique case (cmd_i)
      CMD_PROG:  slot_ok = (op_q == OP_IDLE) ||
                           ((op_q == OP_ERS_SUS) && (req_blk_i != ers_blk_i));
      CMD_ERASE: slot_ok = (op_q == OP_IDLE);
      default:   slot_ok = 1'b0;
    endcase
    pe_try     = live && slot_ok;
    pe_vpp     = pe_try && vpp_lockout_i;
    pe_lock    = pe_try && !vpp_lockout_i && req_locked_i;
    pe_go      = pe_try && !vpp_lockout_i && !req_locked_i;
    susp_go    = live && (cmd_i == CMD_SUSP) && ((op_q == OP_ERS) || (op_q == OP_PRG));
    res_go     = live && (cmd_i == CMD_RESUME) &&
                 ((op_q == OP_ERS_SUS) || (op_q == OP_PRG_SUS));
    lock_we_o  = live && ((cmd_i == CMD_LOCK) || (cmd_i == CMD_UNLOCK));
    lock_set_o = (cmd_i == CMD_LOCK);
    clr        = live && (cmd_i == CMD_CLRST);
    accept_o   = pe_go || susp_go || res_go || lock_we_o || clr;

    op_d = op_q;
    if (hold) begin
      op_d = (op_q == OP_PIES) ? OP_ERS_SUS : OP_IDLE;
    end else if (pe_go) begin
      if (cmd_i == CMD_ERASE)    op_d = OP_ERS;
      else if (op_q == OP_IDLE)  op_d = OP_PRG;
      else                       op_d = OP_PIES;
    end else if (susp_go) begin
      op_d = (op_q == OP_ERS) ? OP_ERS_SUS : OP_PRG_SUS;
    end else if (res_go) begin
      op_d = (op_q == OP_ERS_SUS) ? OP_ERS : OP_PRG;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= OP_IDLE;
      ers_q   <= '0;
      prg_q   <= '0;
      lkerr_q <= 1'b0;
      vperr_q <= 1'b0;
    end else begin
      op_q <= op_d;
      if (pe_go && (cmd_i == CMD_ERASE)) ers_q <= req_addr_i;
      if (pe_go && (cmd_i == CMD_PROG))  prg_q <= req_addr_i;
      if (clr) begin
        lkerr_q <= 1'b0;
        vperr_q <= 1'b0;
      end else begin
        lkerr_q <= lkerr_q | pe_lock;
        vperr_q <= vperr_q | pe_vpp;
      end
    end
  end

  assign op_o       = op_q;
  assign ers_addr_o = ers_q;
  assign prg_addr_o = prg_q;
  assign lock_err_o = lkerr_q;
  assign vpp_err_o  = vperr_q;
endmodule

// File: rtl/fpe_rd_guard.sv
module fpe_rd_guard
  import fpe_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int BANK_W = 4,
  parameter int BLK_W  = 9
) (
  input  fpe_op_e           op_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [BANK_W-1:0] rd_bank_i,
  input  logic [BLK_W-1:0]  rd_blk_i,
  input  logic [BANK_W-1:0] ers_bank_i,
  input  logic [BLK_W-1:0]  ers_blk_i,
  input  logic [BANK_W-1:0] prg_bank_i,
  input  logic [ADDR_W-1:0] prg_addr_i,
  output logic              rd_ok_o
);
  always_comb begin
    unique case (op_i)
      OP_ERS:     rd_ok_o = (rd_bank_i != ers_bank_i);
      OP_PRG:     rd_ok_o = (rd_bank_i != prg_bank_i);
      OP_ERS_SUS: rd_ok_o = (rd_blk_i != ers_blk_i);
      OP_PRG_SUS: rd_ok_o = (rd_addr_i != prg_addr_i);
      OP_PIES:    rd_ok_o = (rd_bank_i != prg_bank_i) && (rd_blk_i != ers_blk_i);
      default:    rd_ok_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/fpe_seq_ctrl.sv
module fpe_seq_ctrl
  import fpe_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int BANK_W      = 4,
  parameter int MAIN_OFS_W  = 16,
  parameter int PARAM_OFS_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [2:0]        req_cmd_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              done_i,
  input  logic              vpp_lockout_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              rd_ok_o,
  output logic              accept_o,
  output logic [ST_W-1:0]   status_o
);
  localparam int NUM_PARAM = 1 << (MAIN_OFS_W - PARAM_OFS_W);
  localparam int NUM_SEC   = 1 << (ADDR_W - MAIN_OFS_W);
  localparam int NBLK      = NUM_SEC - 1 + NUM_PARAM;
  localparam int BLK_W     = $clog2(NBLK);
  localparam int MAP_N     = 3;   // request, read, stored erase

  fpe_op_e op;
  logic [ADDR_W-1:0] ers_addr, prg_addr;
  logic [ADDR_W-1:0] map_addr [MAP_N];
  logic [BLK_W-1:0]  map_blk  [MAP_N];
  logic lock_we, lock_set, req_locked, lock_err, vpp_err;

  assign map_addr[0] = req_addr_i;
  assign map_addr[1] = rd_addr_i;
  assign map_addr[2] = ers_addr;

  for (genvar g = 0; g < MAP_N; g++) begin : g_map
    fpe_addr_map #(
      .ADDR_W(ADDR_W), .MAIN_OFS_W(MAIN_OFS_W),
      .PARAM_OFS_W(PARAM_OFS_W), .BLK_W(BLK_W)
    ) u_map (
      .addr_i(map_addr[g]),
      .blk_o (map_blk[g])
    );
  end

  fpe_lock_bank #(.NBLK(NBLK), .BLK_W(BLK_W)) u_locks (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (lock_we),
    .set_i   (lock_set),
    .blk_i   (map_blk[0]),
    .locked_o(req_locked)
  );

  fpe_op_fsm #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .cmd_i        (fpe_cmd_e'(req_cmd_i)),
    .req_addr_i   (req_addr_i),
    .req_blk_i    (map_blk[0]),
    .req_locked_i (req_locked),
    .ers_blk_i    (map_blk[2]),
    .vpp_lockout_i(vpp_lockout_i),
    .done_i       (done_i),
    .accept_o     (accept_o),
    .lock_we_o    (lock_we),
    .lock_set_o   (lock_set),
    .op_o         (op),
    .ers_addr_o   (ers_addr),
    .prg_addr_o   (prg_addr),
    .lock_err_o   (lock_err),
    .vpp_err_o    (vpp_err)
  );

  fpe_rd_guard #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .BLK_W(BLK_W)) u_guard (
    .op_i      (op),
    .rd_addr_i (rd_addr_i),
    .rd_bank_i (rd_addr_i[ADDR_W-1 -: BANK_W]),
    .rd_blk_i  (map_blk[1]),
    .ers_bank_i(ers_addr[ADDR_W-1 -: BANK_W]),
    .ers_blk_i (map_blk[2]),
    .prg_bank_i(prg_addr[ADDR_W-1 -: BANK_W]),
    .prg_addr_i(prg_addr),
    .rd_ok_o   (rd_ok_o)
  );

  always_comb begin
    status_o           = '0;
    status_o[ST_READY] = !((op == OP_ERS) || (op == OP_PRG) || (op == OP_PIES));
    status_o[ST_ESUS]  = (op == OP_ERS_SUS) || (op == OP_PIES);
    status_o[ST_PSUS]  = (op == OP_PRG_SUS);
    status_o[ST_LKERR] = lock_err;
    status_o[ST_VPERR] = vpp_err;
  end
endmodule

// File: rtl/fpe_seq_ctrl_chk.sv
module fpe_seq_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic [2:0] req_cmd_i,
  input logic       vpp_lockout_i,
  input logic       rd_ok_o,
  input logic       accept_o,
  input logic [4:0] status_o
);
  logic pe_req;
  assign pe_req = req_valid_i && ((req_cmd_i == 3'd1) || (req_cmd_i == 3'd2));

  assert_lockout_refuse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pe_req && vpp_lockout_i |-> !accept_o);

  assert_lockout_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pe_req && vpp_lockout_i && status_o[0] && !status_o[1] && !status_o[2]
    |=> status_o[4]);

  assert_single_op_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pe_req && !status_o[0] |-> !accept_o);

  assert_busy_after_start_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pe_req && accept_o |=> !status_o[0]);

  assert_susp_excl_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(status_o[2:1]));

  assert_err_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[3] && !(req_valid_i && req_cmd_i == 3'd7) |=> status_o[3]);

  assert_idle_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[0] && !status_o[1] && !status_o[2] |-> rd_ok_o);

  assert_resume_only_susp_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_cmd_i == 3'd4 && !status_o[1] && !status_o[2] |-> !accept_o);
endmodule

bind fpe_seq_ctrl fpe_seq_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_cmd_i    (req_cmd_i),
  .vpp_lockout_i(vpp_lockout_i),
  .rd_ok_o      (rd_ok_o),
  .accept_o     (accept_o),
  .status_o     (status_o)
);

// File: tb/fpe_seq_ctrl_tb_top.sv
`timescale 1ns/100ps
module fpe_seq_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_cmd = 3'd0;
  logic [23:0] req_addr = '0;
  logic done = 1'b0;
  logic vpp = 1'b0;
  logic [23:0] rd_addr = '0;
  logic rd_ok, accept;
  logic [4:0] status;

  int checks = 0;
  int fails = 0;

  // reference model state: 0 idle,1 erase,2 program,3 erase-susp,4 program-susp,5 program in erase-susp
  int m_st = 0;
  int m_ers = 0;
  int m_prg = 0;
  bit m_lkerr = 0;
  bit m_vperr = 0;
  bit m_lock [259];

  always #2.5 clk = ~clk;

  fpe_seq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_cmd_i(req_cmd),
    .req_addr_i(req_addr), .done_i(done), .vpp_lockout_i(vpp), .rd_addr_i(rd_addr),
    .rd_ok_o(rd_ok), .accept_o(accept), .status_o(status)
  );

  function automatic int blk_of(int a);
    if (a < 65536) return a / 16384;
    return a / 65536 + 3;
  endfunction

  function automatic int bank_of(int a);
    return a / 1048576;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(string tag, bit v, int cmd, int a, bit dn, bit vp, int ra);
    bit running, hold, acc, exp_rd;
    int nst;
    @(negedge clk);
    req_valid = v; req_cmd = cmd[2:0]; req_addr = a[23:0];
    done = dn; vpp = vp; rd_addr = ra[23:0];
    #1;
    running = (m_st == 1) || (m_st == 2) || (m_st == 5);
    hold = running && dn;
    case (m_st)
      1: exp_rd = bank_of(ra) != bank_of(m_ers);
      2: exp_rd = bank_of(ra) != bank_of(m_prg);
      3: exp_rd = blk_of(ra) != blk_of(m_ers);
      4: exp_rd = ra != m_prg;
      5: exp_rd = (bank_of(ra) != bank_of(m_prg)) && (blk_of(ra) != blk_of(m_ers));
      default: exp_rd = 1;
    endcase
    check(tag, "status", int'(status),
          {27'd0, m_vperr, m_lkerr, m_st == 4, (m_st == 3) || (m_st == 5),
           (m_st == 0) || (m_st == 3) || (m_st == 4)});
    check(tag, "rd_ok", int'(rd_ok), int'(exp_rd));
    acc = 0;
    nst = m_st;
    if (hold) begin
      nst = (m_st == 5) ? 3 : 0;
    end else if (v) begin
      case (cmd)
        1, 2: if ((m_st == 0) || (cmd == 1 && m_st == 3 && blk_of(a) != blk_of(m_ers))) begin
          if (vp) m_vperr = 1;
          else if (m_lock[blk_of(a)]) m_lkerr = 1;
          else begin
            acc = 1;
            if (cmd == 2) begin nst = 1; m_ers = a; end
            else begin nst = (m_st == 0) ? 2 : 5; m_prg = a; end
          end
        end
        3: if (m_st == 1 || m_st == 2) begin acc = 1; nst = m_st + 2; end
        4: if (m_st == 3 || m_st == 4) begin acc = 1; nst = m_st - 2; end
        5: begin acc = 1; m_lock[blk_of(a)] = 1; end
        6: begin acc = 1; m_lock[blk_of(a)] = 0; end
        7: begin acc = 1; m_lkerr = 0; m_vperr = 0; end
        default: ;
      endcase
    end
    check(tag, "accept", int'(accept), int'(acc));
    @(posedge clk);
    m_st = nst;
  endtask

  task automatic idle(string tag, int ra);
    step(tag, 0, 0, 0, 0, 0, ra);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    foreach (m_lock[i]) m_lock[i] = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2 reset state
    idle("R2", 24'h000000);
    idle("R2", 24'hFFFFFF);
    // R3 locked block refused, R12 sticky then cleared
    step("R3", 1, 1, 24'h000000, 0, 0, 0);
    idle("R12", 0);
    step("R12", 1, 2, 24'h500000, 0, 0, 0);
    step("R12", 1, 7, 0, 0, 0, 0);
    idle("R12", 0);
    // R4 lockout beats lock state
    step("R3", 1, 6, 24'h004000, 0, 0, 0);
    step("R4", 1, 1, 24'h004000, 0, 1, 0);
    step("R4", 1, 2, 24'h300000, 0, 1, 0);
    idle("R4", 0);
    step("R12", 1, 7, 0, 0, 0, 0);
    // R1 same block through a different address
    step("R1", 1, 1, 24'h007FFF, 0, 0, 24'h000000);
    idle("R7", 24'h0F0000);
    idle("R7", 24'h100000);
    // R5 second op refused
    step("R5", 1, 1, 24'h004000, 0, 0, 24'h100000);
    step("R5", 1, 2, 24'h004000, 0, 0, 0);
    // R6 done wins over same-cycle request
    step("R6", 1, 6, 24'h100000, 1, 0, 0);
    step("R6", 0, 0, 0, 1, 0, 0);
    step("R1", 1, 1, 24'h008000, 0, 0, 0);
    step("R12", 1, 7, 0, 0, 0, 0);
    step("R1", 1, 6, 24'hFF1234, 0, 0, 0);
    step("R1", 1, 1, 24'hFEFFFF, 0, 0, 0);
    step("R12", 1, 7, 0, 0, 0, 0);
    step("R1", 1, 1, 24'hFFFFFF, 0, 0, 24'hFF0000);
    idle("R7", 24'hEFFFFF);
    step("R6", 0, 0, 0, 1, 0, 0);
    step("R1", 1, 6, 24'h0F8000, 0, 0, 0);
    step("R1", 1, 2, 24'h0F0000, 0, 0, 24'h0FFFFF);
    step("R6", 0, 0, 0, 1, 0, 0);
    step("R1", 1, 6, 24'h100000, 0, 0, 0);
    step("R1", 1, 2, 24'h110000, 0, 0, 0);
    step("R12", 1, 7, 0, 0, 0, 0);
    // R8 erase suspend and program elsewhere
    step("R8", 1, 2, 24'h10FFFF, 0, 0, 0);
    idle("R7", 24'h1FFFFF);
    step("R8", 1, 3, 0, 0, 0, 24'h100005);
    idle("R8", 24'h100005);
    idle("R8", 24'h110000);
    step("R8", 1, 1, 24'h10ABCD, 0, 0, 0);
    step("R8", 1, 2, 24'h004000, 0, 0, 0);
    step("R10", 1, 1, 24'h004000, 0, 0, 0);
    step("R10", 1, 3, 0, 0, 0, 24'h005000);
    idle("R10", 24'h100005);
    idle("R10", 24'h200000);
    idle("R10", 24'h110000);
    step("R10", 0, 0, 0, 1, 0, 24'h005000);
    idle("R10", 24'h005000);
    step("R8", 1, 4, 0, 0, 0, 0);
    idle("R8", 24'h200000);
    step("R6", 0, 0, 0, 1, 0, 0);
    // R9 program suspend
    step("R9", 1, 1, 24'h007000, 0, 0, 0);
    step("R9", 1, 3, 0, 0, 0, 0);
    idle("R9", 24'h007000);
    idle("R9", 24'h007001);
    step("R9", 1, 2, 24'h004000, 0, 0, 0);
    step("R9", 1, 1, 24'h004000, 0, 0, 0);
    step("R11", 1, 3, 0, 0, 0, 0);
    step("R9", 1, 4, 0, 0, 0, 0);
    step("R11", 1, 4, 0, 0, 0, 0);
    step("R6", 0, 0, 0, 1, 0, 0);
    // R11 invalid suspend/resume in idle, done ignored in idle
    step("R11", 1, 3, 0, 0, 0, 0);
    step("R11", 1, 4, 0, 0, 0, 0);
    step("R6", 0, 0, 0, 1, 0, 0);
    // R3 relock takes effect at once
    step("R3", 1, 5, 24'h005555, 0, 0, 0);
    step("R3", 1, 1, 24'h004000, 0, 0, 0);
    idle("R13", 0);
    step("R12", 1, 7, 0, 0, 0, 0);
    idle("R13", 0);
    summary();
  end
endmodule